// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block holds the status and control word for one downstream port of a USB 3 host controller. Software reads the whole 32-bit word and writes it through a single write strobe. The bits follow mixed rules: some keep their value, some take the write data, some are write-1-to-clear, and the link state field moves only when a strobe bit is set. Port-side logic drives sideband inputs for device attach and detach with a speed code, for completion of a hot or warm port reset, and for remote wake from a suspended device.

Each update that needs attention from software raises a one-cycle pulse on `evt_o`. A host controller would turn this pulse into a port status change event. In one cycle the sideband updates are applied first, in a fixed order: connection change, then reset, then wake. The software write is then applied to that result. The new word and the event pulse are both visible one clock after the inputs.

Field positions: connected bit 0, enabled bit 1, over-current active bit 3, reset-in-progress bit 4, link state bits 8:5, power bit 9, speed bits 13:10, indicator bits 15:14, link write strobe bit 16. The change bits are connect 17, enable 18, warm reset 19, over-current 20, reset 21, link state 22 and config error 23. Bit 30 is device removable and bit 31 is warm reset request. The link state codes are U0 = 0, U3 = 3, RxDetect = 5 and Resume = 15.

Top module: `port_status_reg`

## Requirements
- R1: While reset is asserted and after it is released, the word reads 0x0000_02A0 (power set, link state RxDetect) and `evt_o` is 0.
- R2: On attach, the word becomes connected | power | connect change | (speed_i << 10), which is 0x0002_0201 plus the speed field. The device is then marked present, and `evt_o` pulses if `intr_en_i` is 1.
- R3: On detach, connected and enabled are cleared, connect change is set and the link state becomes 5, with the other bits unchanged. The device is marked absent and `evt_o` pulses if `intr_en_i` is 1. When detach and attach arrive together, detach wins and attach is ignored.
- R4: A software write is ignored while the power bit (bit 9) is 0.
- R5: On a software write, the bits in mask 0x00FE_FDE2 (enabled, link state, speed, indicator, change bits) keep their value. The bits in mask 0x3F00_0204 are taken from the write data, and bit 0 equals device-present. Bits 3, 4, 16, 30 and 31 read 0.
- R6: Writing 1 to any of bits 23:17 clears that bit. Writing 0 leaves it unchanged, and a write never sets one.
- R7: When bit 16 of the write data is 1 and data bits 8:5 hold 0 or 3 and differ from the current link state, the link state takes that value. A move to 0 sets bit 22 and pulses `evt_o`, and a move to 3 raises no event. Any other target, or bit 16 equal to 0, leaves the link state unchanged.
- R8: A reset request sets the link state to 0, bit 4 to 0, enabled to 1 and speed to `speed_i`. It sets bit 19 when `reset_warm_i` and `dev_usb3_i` are both 1. It sets bit 21, and `evt_o` pulses only if bit 21 was 0 beforehand.
- R9: A wake while the link state is 3 sets it to 15. If bit 22 was 0, it is set and `evt_o` pulses; otherwise no event is raised. A wake in any other link state has no effect.
- R10: When sideband inputs and a software write arrive in the same cycle, the write is applied to the word already updated by the sideband inputs.
- R11: `evt_o` is a single-cycle pulse in the cycle after its cause. Several causes in one cycle give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attach_i | input | 1 | Device attached this cycle |
| detach_i | input | 1 | Device detached this cycle |
| speed_i | input | 4 | Speed code for attach and reset |
| intr_en_i | input | 1 | Raise event on attach or detach |
| reset_req_i | input | 1 | Port reset completes this cycle |
| reset_warm_i | input | 1 | The reset is a warm reset |
| dev_usb3_i | input | 1 | Attached device is USB 3 |
| wake_i | input | 1 | Remote wake from device |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Current register word |
| evt_o | output | 1 | Port status change event pulse |

## Verification
On every cycle, the assertions check these isolated rules: the attach load, the detach field changes, the hold on unpowered writes, that a write never sets the connect change bit, the wake event, and that the fixed-zero bits stay zero. Only the bench scenarios can show the rest. That covers the ordering of sideband updates against a same-cycle write and the event suppression when a reset or wake finds its change bit already set. It also covers link state moves through the write strobe and the interplay over long random mixes of all inputs.

// File: rtl/portsc_pkg.sv
package portsc_pkg;
  localparam int DW    = 32;
  localparam int SPD_W = 4;
  localparam int PLS_W = 4;

  localparam int CCS = 0;
  localparam int PED = 1;
  localparam int OCA = 3;
  localparam int PRS = 4;
  localparam int PLS_LO = 5;
  localparam int PLS_HI = PLS_LO + PLS_W - 1;
  localparam int PWR = PLS_HI + 1;
  localparam int SPD_LO = PWR + 1;
  localparam int SPD_HI = SPD_LO + SPD_W - 1;
  localparam int LWS = 16;
  localparam int CSC = 17;
  localparam int WRC = 19;
  localparam int PRC = 21;
  localparam int PLC = 22;
  localparam int CHG_LO = 17;
  localparam int CHG_HI = 23;
  localparam int DRM = 30;
  localparam int WPR = 31;

  localparam logic [PLS_W-1:0] LS_U0     = 4'd0;
  localparam logic [PLS_W-1:0] LS_U3     = 4'd3;
  localparam logic [PLS_W-1:0] LS_RXDET  = 4'd5;
  localparam logic [PLS_W-1:0] LS_RESUME = 4'd15;

  localparam logic [DW-1:0] KEEP_M = 32'h00FE_FDE2;
  localparam logic [DW-1:0] DATA_M = 32'h3F00_0204;
  localparam logic [DW-1:0] RSVD_M = (DW'(1) << OCA) | (DW'(1) << PRS) | (DW'(1) << LWS)
                                   | (DW'(1) << DRM) | (DW'(1) << WPR);
  localparam logic [DW-1:0] SPD_M  = ((DW'(1) << SPD_W) - DW'(1)) << SPD_LO;
  localparam logic [DW-1:0] ATTACH_BASE = (DW'(1) << CCS) | (DW'(1) << PWR) | (DW'(1) << CSC);
  localparam logic [DW-1:0] INIT_WORD = (DW'(1) << PWR) | (DW'(LS_RXDET) << PLS_LO);
endpackage

// File: rtl/portsc_side.sv
module portsc_side
  import portsc_pkg::*;
(
  input  logic [DW-1:0]    cur_i,
  input  logic             present_i,
  input  logic             attach_i,
  input  logic             detach_i,
  input  logic [SPD_W-1:0] speed_i,
  input  logic             intr_en_i,
  input  logic             reset_req_i,
  input  logic             reset_warm_i,
  input  logic             dev_usb3_i,
  input  logic             wake_i,
  output logic [DW-1:0]    nxt_o,
  output logic             present_o,
  output logic             evt_o
);
  logic [DW-1:0] v;
  logic          p, e;

  always_comb begin
    v = cur_i;
    p = present_i;
    e = 1'b0;
    // connection change: detach beats attach
    if (detach_i) begin
      v[CCS] = 1'b0;
      v[PED] = 1'b0;
      v[CSC] = 1'b1;
      v[PLS_HI:PLS_LO] = LS_RXDET;
      p = 1'b0;
      e = intr_en_i;
    end else if (attach_i) begin
      v = ATTACH_BASE;
      v[SPD_HI:SPD_LO] = speed_i;
      p = 1'b1;
      e = intr_en_i;
    end
    // reset completion
    if (reset_req_i) begin
      v[PLS_HI:PLS_LO] = LS_U0;
      v[PRS] = 1'b0;
      v[PED] = 1'b1;
      v[SPD_HI:SPD_LO] = speed_i;
      if (reset_warm_i && dev_usb3_i) v[WRC] = 1'b1;
      if (!v[PRC]) begin
        v[PRC] = 1'b1;
        e = 1'b1;
      end
    end
    // remote wake from suspend
    if (wake_i && v[PLS_HI:PLS_LO] == LS_U3) begin
      v[PLS_HI:PLS_LO] = LS_RESUME;
      if (!v[PLC]) begin
        v[PLC] = 1'b1;
        e = 1'b1;
      end
    end
    nxt_o = v;
    present_o = p;
    evt_o = e;
  end
endmodule

// File: rtl/portsc_write.sv
module portsc_write
  import portsc_pkg::*;
(
  input  logic [DW-1:0] cur_i,
  input  logic          present_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] nxt_o,
  output logic          evt_o
);
  logic [DW-1:0]    v;
  logic [PLS_W-1:0] tgt, old_ls;
  logic             e;

  assign tgt    = wr_data_i[PLS_HI:PLS_LO];
  assign old_ls = cur_i[PLS_HI:PLS_LO];

  always_comb begin
    v = cur_i;
    e = 1'b0;
    if (wr_en_i && cur_i[PWR]) begin
      v = (cur_i & KEEP_M) | (wr_data_i & DATA_M);
      v[CCS] = present_i;
      v[CHG_HI:CHG_LO] = cur_i[CHG_HI:CHG_LO] & ~wr_data_i[CHG_HI:CHG_LO];
      if (wr_data_i[LWS] && (tgt == LS_U0 || tgt == LS_U3) && tgt != old_ls) begin
        v[PLS_HI:PLS_LO] = tgt;
        if (tgt == LS_U0) begin
          v[PLC] = 1'b1;
          e = 1'b1;
        end
      end
    end
    nxt_o = v;
    evt_o = e;
  end
endmodule

// File: rtl/port_status_reg.sv
module port_status_reg
  import portsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             attach_i,
  input  logic             detach_i,
  input  logic [SPD_W-1:0] speed_i,
  input  logic             intr_en_i,
  input  logic             reset_req_i,
  input  logic             reset_warm_i,
  input  logic             dev_usb3_i,
  input  logic             wake_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             evt_o
);
  logic [DW-1:0] sc_q, side_w, wr_w;
  logic          present_q, side_p, side_e, wr_e, evt_q;

  portsc_side u_side (
    .cur_i       (sc_q),
    .present_i   (present_q),
    .attach_i    (attach_i),
    .detach_i    (detach_i),
    .speed_i     (speed_i),
    .intr_en_i   (intr_en_i),
    .reset_req_i (reset_req_i),
    .reset_warm_i(reset_warm_i),
    .dev_usb3_i  (dev_usb3_i),
    .wake_i      (wake_i),
    .nxt_o       (side_w),
    .present_o   (side_p),
    .evt_o       (side_e)
  );

  // write sees the word after sideband updates
  portsc_write u_write (
    .cur_i    (side_w),
    .present_i(side_p),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .nxt_o    (wr_w),
    .evt_o    (wr_e)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q      <= INIT_WORD;
      present_q <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      sc_q      <= wr_w;
      present_q <= side_p;
      evt_q     <= side_e | wr_e;
    end
  end

  assign rd_data_o = sc_q;
  assign evt_o     = evt_q;

  logic sb_idle;
  assign sb_idle = !(attach_i || detach_i || reset_req_i || wake_i);

  a_r2_attach_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attach_i && !detach_i && !reset_req_i && !wake_i && !wr_en_i |=>
      (rd_data_o & ~SPD_M) == ATTACH_BASE && rd_data_o[SPD_HI:SPD_LO] == $past(speed_i));

  a_r3_detach_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_i && !wr_en_i |=>
      !rd_data_o[CCS] && !rd_data_o[PED] && rd_data_o[CSC]
      && (rd_data_o[PLS_HI:PLS_LO] == LS_RXDET || (rd_data_o[PLS_HI:PLS_LO] == LS_U0 && rd_data_o[PRC])));

  a_r4_unpowered_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_idle && wr_en_i && !rd_data_o[PWR] |=> $stable(rd_data_o));

  a_r6_write_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_idle && wr_en_i && !rd_data_o[CSC] |=> !rd_data_o[CSC]);

  a_r9_wake_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i && !attach_i && !detach_i && !reset_req_i && !wr_en_i
    && rd_data_o[PLS_HI:PLS_LO] == LS_U3 && !rd_data_o[PLC] |=>
      evt_o && rd_data_o[PLS_HI:PLS_LO] == LS_RESUME && rd_data_o[PLC]);

  a_r5_fixed_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & RSVD_M) == '0);
endmodule

// File: tb/port_status_reg_test.sv
module port_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        attach_i = 0, detach_i = 0, intr_en_i = 0;
  logic [3:0]  speed_i = 0;
  logic        reset_req_i = 0, reset_warm_i = 0, dev_usb3_i = 0, wake_i = 0;
  logic        wr_en_i = 0;
  logic [31:0] wr_data_i = 0;
  logic [31:0] rd_data_o;
  logic        evt_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] m_q;
  logic        m_p, m_e;

  always #4 clk = ~clk;

  port_status_reg uut (
    .clk_i(clk), .rst_ni(rst_ni), .attach_i(attach_i), .detach_i(detach_i),
    .speed_i(speed_i), .intr_en_i(intr_en_i), .reset_req_i(reset_req_i),
    .reset_warm_i(reset_warm_i), .dev_usb3_i(dev_usb3_i), .wake_i(wake_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .evt_o(evt_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // expected next word from the requirements
  task automatic model(input logic att, det, input logic [3:0] spd, input logic ien, rr, wm, u3, wk,
                       input logic we, input logic [31:0] wd);
    logic [31:0] v, nv;
    logic [3:0]  t;
    logic        p, e;
    v = m_q; p = m_p; e = 1'b0;
    if (det) begin
      v = (v & ~32'h0000_01E3) | 32'h0002_0000 | (32'd5 << 5);
      p = 1'b0; e = ien;
    end else if (att) begin
      v = 32'h0002_0201 | ({28'd0, spd} << 10);
      p = 1'b1; e = ien;
    end
    if (rr) begin
      v = (v & ~32'h0000_3DF0) | 32'h2 | ({28'd0, spd} << 10);
      if (wm && u3) v = v | 32'h0008_0000;
      if (v[21] == 1'b0) begin v = v | 32'h0020_0000; e = 1'b1; end
    end
    if (wk && v[8:5] == 4'd3) begin
      v[8:5] = 4'd15;
      if (v[22] == 1'b0) begin v[22] = 1'b1; e = 1'b1; end
    end
    if (we && v[9]) begin
      nv = (v & 32'h00FE_FDE2) | (wd & 32'h3F00_0204) | {31'd0, p};
      nv = nv & ~(wd & 32'h00FE_0000);
      t = wd[8:5];
      if (wd[16] && (t == 4'd0 || t == 4'd3) && t != v[8:5]) begin
        nv[8:5] = t;
        if (t == 4'd0) begin nv[22] = 1'b1; e = 1'b1; end
      end
      v = nv;
    end
    m_q = v; m_p = p; m_e = e;
  endtask

  task automatic step(input string tag, input logic att, det, input logic [3:0] spd,
                      input logic ien, rr, wm, u3, wk, input logic we, input logic [31:0] wd);
    attach_i = att; detach_i = det; speed_i = spd; intr_en_i = ien;
    reset_req_i = rr; reset_warm_i = wm; dev_usb3_i = u3; wake_i = wk;
    wr_en_i = we; wr_data_i = wd;
    model(att, det, spd, ien, rr, wm, u3, wk, we, wd);
    @(posedge clk); #1;
    chk(tag, rd_data_o, m_q);
    chk({tag, " evt"}, {31'd0, evt_o}, {31'd0, m_e});
    @(negedge clk);
    attach_i = 0; detach_i = 0; reset_req_i = 0; wake_i = 0; wr_en_i = 0;
  endtask

  task automatic swr(input string tag, input logic [31:0] wd);
    step(tag, 0, 0, 4'd0, 0, 0, 0, 0, 0, 1, wd);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_q = 32'h0000_02A0; m_p = 1'b0; m_e = 1'b0;
    #10;
    chk("R1 in reset", rd_data_o, 32'h0000_02A0);
    chk("R1 evt in reset", {31'd0, evt_o}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_data_o, 32'h0000_02A0);

    swr("R7 to U3 no event", 32'h0001_0260);
    step("R9 wake from U3", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9 link resume", {28'd0, rd_data_o[8:5]}, 32'd15);
    swr("R7 to U0 with PLC set", 32'h0001_0200);
    swr("R7 same U0 no change", 32'h0001_0200);
    swr("R7 target 5 ignored", 32'h0001_02A0);
    swr("R7 no strobe ignored", 32'h0000_0260);
    swr("R6 clear PLC", 32'h0040_0200);
    step("R2 attach", 1, 0, 4'd3, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 attach word", rd_data_o, 32'h0002_0E01);
    swr("R6 clear CSC", 32'h0002_0200);
    swr("R6 write zero keeps", 32'h0000_0200);
    step("R8 hot reset event", 0, 0, 4'd4, 0, 1, 0, 0, 0, 0, 0);
    step("R8 reset PRC set no event", 0, 0, 4'd4, 0, 1, 0, 0, 0, 0, 0);
    swr("R6 clear PRC", 32'h0020_0200);
    step("R8 warm usb3 reset", 0, 0, 4'd4, 0, 1, 1, 1, 0, 0, 0);
    swr("R7 to U3 attached", 32'h0001_0260);
    step("R9 wake event", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R11 evt drops", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    swr("R7 back to U0", 32'h0001_0200);
    swr("R7 U3 again", 32'h0001_0260);
    step("R9 wake PLC set no event", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R9 wake not in U3", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    swr("R5 data bits and fixed zeros", 32'hFFC1_C21F);
    swr("R4 power off", 32'h0000_0000);
    swr("R4 unpowered write ignored", 32'hFFFF_FFFF);
    chk("R4 power still off", {31'd0, rd_data_o[9]}, 32'd0);
    step("R3 detach no intr", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 detach beats attach", 1, 1, 4'd2, 1, 0, 0, 0, 0, 0, 0);
    step("R10 attach then write clears CSC", 1, 0, 4'd2, 0, 0, 0, 0, 0, 1, 32'h0002_0200);
    chk("R10 CSC cleared", {31'd0, rd_data_o[17]}, 32'd0);
    step("R10 reset then write to U3", 0, 0, 4'd1, 0, 1, 0, 0, 0, 1, 32'h0001_0260);
    step("R11 wake and write one pulse", 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h0001_0200);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      logic [3:0]  sel;
      sel = 4'($urandom_range(0, 15));
      wd = $urandom;
      if ($urandom_range(0, 7) != 0) wd[9] = 1'b1;
      if ($urandom_range(0, 1) != 0) wd[8:5] = ($urandom_range(0, 1) != 0) ? 4'd0 : 4'd3;
      if ($urandom_range(0, 3) != 0) wd[23:17] = 7'($urandom_range(0, 127)) & 7'h11;
      step("R10 random mix", sel == 0, sel == 1, 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), sel == 2 || sel == 3, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), sel == 4 || sel == 5,
           1'($urandom_range(0, 2) != 0), wd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule